// File: doc/BRIEF.md
# SDRAM Command Timing Checker

A passive monitor for a single-rank SDR SDRAM command bus. It samples the clock enable, chip select, the three command strobes, the address and the two bank bits on every rising edge. From these it decodes each command, keeps an open/closed flag and age counters for each of four banks, and measures every cycle-count minimum between commands. It also measures the gap since the last refresh. It never drives the bus.

Each rule owns one bit of a sticky error vector. That bit is set in the cycle after the offending edge and stays set until reset. A single pulse output goes high for one cycle after any edge that broke at least one rule. All minimum distances and the refresh limit are parameters. The defaults fit a part clocked near 100 MHz: activate-to-column 2, precharge-to-activate 2, activate-to-precharge 5, row cycle 7, bank-to-bank activate 2, mode-set recovery 2, refresh gap 780 cycles.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is decoded only when `cs_n` is low. The strobes `{ras_n,cas_n,we_n}` encode 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set and 111 no-op. With `cs_n` high the edge is a deselect, and no bank state changes and no error is raised.
- R2: If `cke` was low at the previous rising edge, the current edge is ignored. No state is updated and no rule is checked for a command on that edge.
- R3: A precharge with `addr[10]` high closes all four banks. With `addr[10]` low it closes only the bank selected by `ba`.
- R4: A read or write to a bank fewer than T_RCD cycles after that bank's activate sets bit 0.
- R5: An activate fewer than T_RP cycles after a precharge of the same bank sets bit 1. A precharge reaching an open bank fewer than T_RAS cycles after its activate sets bit 2.
- R6: An activate fewer than T_RC cycles after the previous activate of the same bank sets bit 3. An activate or refresh fewer than T_RC cycles after a refresh sets bit 4.
- R7: An activate to a bank other than the last activated one, fewer than T_RRD cycles after that activate, sets bit 5.
- R8: Any decoded command other than a no-op fewer than T_MRD cycles after a mode set sets bit 6.
- R9: Bit 7 is set when REFI_LIMIT cycles have passed since the last refresh (or since reset) and the current edge is not a refresh. It fires once per overrun.
- R10: Bit 8 is set by a read or write to a closed bank, by an activate to an open bank, or by a refresh while any bank is open.
- R11: After reset both outputs are zero. `err_sticky` bits set one cycle after the offending edge and clear only on reset. `err_pulse` is high exactly in the cycles that follow a violating edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| addr | input | ADDR_W | Address bus; bit AP_BIT selects all-bank precharge |
| ba | input | 2 | Bank select |
| err_sticky | output | 9 | One sticky bit per rule (bit order per R4 to R10) |
| err_pulse | output | 1 | High for one cycle after any violating edge |

## Verification
The assertions assume that `rst_n` is held low across at least one rising edge before the bus is used. They also assume that `cke` and the command lines are clean digital levels sampled on the rising edge. The bench drives every input on the falling edge, keeps `cke` high except in the gating test, and releases reset only between scenarios. A behavioural reference model in the bench tracks the edge numbers of past commands and predicts every bit on every cycle. This includes cases that sit exactly on each minimum and cases one cycle short of it.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RAS      = 5,
  parameter int T_RC       = 7,
  parameter int T_RRD      = 2,
  parameter int T_MRD      = 2,
  parameter int REFI_LIMIT = 780,
  parameter int ADDR_W     = 13,
  parameter int AP_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ba,
  output logic [8:0]        err_sticky,
  output logic              err_pulse
);
  localparam int CW = $clog2(T_RCD + T_RP + T_RAS + T_RC + T_RRD + T_MRD + 2);
  localparam int RW = $clog2(REFI_LIMIT + 2);
  localparam logic [CW-1:0] SAT   = {CW{1'b1}};
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);
  localparam logic [RW-1:0] L_REFI     = RW'(REFI_LIMIT);
  localparam logic [RW-1:0] L_REFI_TOP = RW'(REFI_LIMIT + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic                cke_q;
  logic [3:0]          open_q;
  logic [3:0][CW-1:0]  act_age, pre_age;
  logic [CW-1:0]       any_act_age, ref_age, mrs_age;
  logic [1:0]          last_bank;
  logic [RW-1:0]       refi_cnt;
  logic [8:0]          viol;
  logic [3:0]          ras_short;

  function automatic logic [CW-1:0] age_step(input logic [CW-1:0] a);
    return (a == SAT) ? a : a + ONE;
  endfunction

  wire       cmd_ok = cke_q & ~cs_n;
  wire [2:0] op     = {ras_n, cas_n, we_n};
  wire is_act = cmd_ok && op == 3'b011;
  wire is_rd  = cmd_ok && op == 3'b101;
  wire is_wr  = cmd_ok && op == 3'b100;
  wire is_pre = cmd_ok && op == 3'b010;
  wire is_ref = cmd_ok && op == 3'b001;
  wire is_mrs = cmd_ok && op == 3'b000;
  wire is_nop = op == 3'b111;
  wire is_col = is_rd | is_wr;

  wire [3:0] sel      = 4'b0001 << ba;
  wire [3:0] pre_mask = addr[AP_BIT] ? 4'hF : sel;

  always_comb
    for (int b = 0; b < 4; b++) ras_short[b] = act_age[b] < L_RAS;

  assign viol[0] = is_col && act_age[ba] < L_RCD;
  assign viol[1] = is_act && pre_age[ba] < L_RP;
  assign viol[2] = is_pre && |(pre_mask & open_q & ras_short);
  assign viol[3] = is_act && act_age[ba] < L_RC;
  assign viol[4] = (is_act | is_ref) && ref_age < L_RC;
  assign viol[5] = is_act && last_bank != ba && any_act_age < L_RRD;
  assign viol[6] = cmd_ok && !is_nop && mrs_age < L_MRD;
  assign viol[7] = refi_cnt == L_REFI && !is_ref;
  assign viol[8] = (is_col && !open_q[ba]) || (is_act && open_q[ba]) || (is_ref && |open_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      open_q      <= '0;
      act_age     <= {4{SAT}};
      pre_age     <= {4{SAT}};
      any_act_age <= SAT;
      ref_age     <= SAT;
      mrs_age     <= SAT;
      last_bank   <= '0;
      refi_cnt    <= '0;
      err_sticky  <= '0;
      err_pulse   <= 1'b0;
    end else begin
      cke_q <= cke;
      for (int b = 0; b < 4; b++) begin
        act_age[b] <= (is_act && sel[b]) ? ONE : age_step(act_age[b]);
        pre_age[b] <= (is_pre && pre_mask[b]) ? ONE : age_step(pre_age[b]);
        if (is_act && sel[b])           open_q[b] <= 1'b1;
        else if (is_pre && pre_mask[b]) open_q[b] <= 1'b0;
      end
      any_act_age <= is_act ? ONE : age_step(any_act_age);
      ref_age     <= is_ref ? ONE : age_step(ref_age);
      mrs_age     <= is_mrs ? ONE : age_step(mrs_age);
      if (is_act) last_bank <= ba;
      if (is_ref)                      refi_cnt <= RW'(1);
      else if (refi_cnt != L_REFI_TOP) refi_cnt <= refi_cnt + RW'(1);
      err_sticky <= err_sticky | viol;
      err_pulse  <= |viol;
    end
  end

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(open_q));

  p_gated_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 $stable(open_q));

  p_allbank_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && addr[AP_BIT]) |=> open_q == 4'h0);

  p_rcd_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky[0]) |-> $past(is_col));

  p_sticky_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_sticky) & ~err_sticky) == 9'h0);

  p_pulse_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky != 9'h0);
endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, T_RC = 7, T_RRD = 2, T_MRD = 2;
  localparam int REFI = 300;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                         C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [1:0] ba = '0;
  logic [8:0] err_sticky;
  logic err_pulse;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sdram_cmd_checker #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_MRD(T_MRD), .REFI_LIMIT(REFI)) u_sdram_cmd_checker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .err_sticky(err_sticky), .err_pulse(err_pulse));

  // reference model: edge numbers of past events
  int n, last_act[4], last_pre[4], last_ref, last_refi, last_mrs, last_any, last_bank;
  bit open_m[4], cke_prev, live, exp_pulse;
  logic [8:0] exp_sticky;

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; last_ref = -1000; last_refi = 0; last_mrs = -1000; last_any = -1000;
      last_bank = 0; cke_prev = 1; live = 0; exp_pulse = 0; exp_sticky = '0;
      for (int b = 0; b < 4; b++) begin
        last_act[b] = -1000; last_pre[b] = -1000; open_m[b] = 0;
      end
    end else begin
      logic [8:0] v;
      bit valid;
      int b;
      v = '0;
      valid = cke_prev && !cs_n;
      b = int'(ba);
      if (valid && {ras_n, cas_n, we_n} != C_NOP && n - last_mrs < T_MRD) v[6] = 1;
      if (n - last_refi == REFI && !(valid && {ras_n, cas_n, we_n} == C_REF)) v[7] = 1;
      if (valid) begin
        case ({ras_n, cas_n, we_n})
          C_ACT: begin
            if (n - last_pre[b] < T_RP) v[1] = 1;
            if (n - last_act[b] < T_RC) v[3] = 1;
            if (n - last_ref < T_RC) v[4] = 1;
            if (b != last_bank && n - last_any < T_RRD) v[5] = 1;
            if (open_m[b]) v[8] = 1;
            open_m[b] = 1; last_act[b] = n; last_any = n; last_bank = b;
          end
          C_RD, C_WR: begin
            if (n - last_act[b] < T_RCD) v[0] = 1;
            if (!open_m[b]) v[8] = 1;
          end
          C_PRE: begin
            for (int k = 0; k < 4; k++) if (addr[10] || k == b) begin
              if (open_m[k] && n - last_act[k] < T_RAS) v[2] = 1;
              open_m[k] = 0; last_pre[k] = n;
            end
          end
          C_REF: begin
            if (n - last_ref < T_RC) v[4] = 1;
            for (int k = 0; k < 4; k++) if (open_m[k]) v[8] = 1;
            last_ref = n; last_refi = n;
          end
          C_MRS: last_mrs = n;
          default: ;
        endcase
      end
      exp_pulse = |v;
      exp_sticky = exp_sticky | v;
      cke_prev = cke;
      n = n + 1;
      live = 1;
    end
  end

  function automatic string tag_of(int i);
    case (i)
      0: return "R4";
      1, 2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) if (rst_n && live) begin
    for (int i = 0; i < 9; i++) begin
      checks++;
      if (err_sticky[i] !== exp_sticky[i]) begin
        errors++;
        $display("FAIL %s bit %0d: got %b expected %b", tag_of(i), i, err_sticky[i], exp_sticky[i]);
      end
    end
    checks++;
    if (err_pulse !== exp_pulse) begin
      errors++;
      $display("FAIL R11 pulse: got %b expected %b", err_pulse, exp_pulse);
    end
  end

  task automatic expect_vec(input logic [8:0] want, input string tag);
    checks++;
    if (err_sticky !== want) begin
      errors++;
      $display("FAIL %s sticky: got %h expected %h", tag, err_sticky, want);
    end
  endtask

  task automatic expect_pulse(input bit want, input string tag);
    checks++;
    if (err_pulse !== want) begin
      errors++;
      $display("FAIL %s pulse: got %b expected %b", tag, err_pulse, want);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input int b, input bit ap,
                     input bit desel = 0, input bit ck = 1);
    {ras_n, cas_n, we_n} = c;
    ba = 2'(b);
    addr = '0;
    addr[10] = ap;
    cs_n = desel;
    cke = ck;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cmd(C_NOP, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = C_NOP;
    repeat (2) @(negedge clk);
    rst_n = 1;
    expect_vec('0, "R11");
    expect_pulse(0, "R11");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 reset state, then a legal sequence exactly on the R4 R5 R6 minimums
    do_reset();
    cmd(C_ACT, 0, 0); idle(1); cmd(C_RD, 0, 0); cmd(C_WR, 0, 0); idle(1);
    cmd(C_PRE, 0, 0); idle(1); cmd(C_ACT, 0, 0);
    expect_vec('0, "R4");
    // R4 column too early
    do_reset();
    cmd(C_ACT, 1, 0); cmd(C_RD, 1, 0);
    expect_pulse(1, "R11");
    expect_vec(9'h001, "R4");
    idle(1);
    expect_pulse(0, "R11");
    // R5 and R6 same-bank spacing
    do_reset();
    cmd(C_ACT, 2, 0); cmd(C_PRE, 2, 0); cmd(C_ACT, 2, 0);
    expect_vec(9'h00E, "R5");
    // R6 refresh to activate
    do_reset();
    cmd(C_REF, 0, 0); idle(2); cmd(C_ACT, 0, 0);
    expect_vec(9'h010, "R6");
    // R7 bank to bank
    do_reset();
    cmd(C_ACT, 0, 0); cmd(C_ACT, 1, 0);
    expect_vec(9'h020, "R7");
    // R8 mode set recovery
    do_reset();
    cmd(C_MRS, 0, 0); cmd(C_ACT, 0, 0, 1); cmd(C_NOP, 0, 0);
    expect_vec('0, "R8");
    cmd(C_MRS, 0, 0); cmd(C_ACT, 0, 0);
    expect_vec(9'h040, "R8");
    // R10 state errors
    do_reset();
    cmd(C_RD, 0, 0);
    expect_vec(9'h100, "R10");
    do_reset();
    cmd(C_ACT, 2, 0); idle(10); cmd(C_REF, 0, 0);
    expect_vec(9'h100, "R10");
    // R3 all-bank precharge
    do_reset();
    cmd(C_ACT, 0, 0); idle(1); cmd(C_ACT, 1, 0); idle(5);
    cmd(C_PRE, 0, 1); idle(1); cmd(C_RD, 1, 0);
    expect_vec(9'h100, "R3");
    // R3 single-bank precharge
    do_reset();
    cmd(C_ACT, 0, 0); idle(1); cmd(C_ACT, 1, 0); idle(5);
    cmd(C_PRE, 0, 0); idle(1); cmd(C_RD, 1, 0);
    expect_vec('0, "R3");
    cmd(C_RD, 0, 0);
    expect_vec(9'h100, "R3");
    // R2 gated edges ignored
    do_reset();
    cmd(C_NOP, 0, 0, 0, 0); cmd(C_RD, 0, 0);
    expect_vec('0, "R2");
    cmd(C_NOP, 0, 0, 0, 0); cmd(C_ACT, 0, 0); idle(3); cmd(C_RD, 0, 0);
    expect_vec(9'h100, "R2");
    // R1 deselect ignored
    do_reset();
    cmd(C_RD, 0, 0, 1);
    expect_vec('0, "R1");
    expect_pulse(0, "R1");
    // R9 refresh interval
    do_reset();
    idle(150); cmd(C_REF, 0, 0);
    expect_vec('0, "R9");
    idle(310);
    expect_vec(9'h080, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule